// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block derives the timing strobes used by a bank of PWM channels from one master PWM clock. Nothing is a gated clock: every output is a single-cycle enable pulse in the master clock domain. A free-running power-of-two prescaler provides eleven tap strobes, at the master rate divided by 1, 2, 4 and so on up to 1024.

Two independent linear dividers, A and B, each select one of the eleven taps and emit one pulse for every N pulses of that tap. N is a programmable divide value from 1 to 255, and a divide value of zero turns the derived strobe off. The mode fields that choose the tap and the divide value come straight in as inputs.

A master-enable input stands in for the PWM master clock being switched off. While it is low, and during reset, only the undivided tap stays active. The channel logic downstream picks whichever strobe it needs as its count enable.

Top module: `pwm_clkgen`

## Requirements
- R1: Output bit `tap_o[k]` (k from 0 to 10) carries the tap with ratio 2^k. While enabled, tap k pulses high for one master cycle once every 2^k cycles.
- R2: `tap_o[0]` is high in every cycle, including during reset and while `enable_i` is low.
- R3: While `rst_n` is low, `tap_o[10:1]`, `clk_a_o` and `clk_b_o` are all low. Reset clears the prescaler count and each divider's stored select and divide values to zero.
- R4: Select value k (0 to 10) on `sel_a_i` picks tap k for divider A, and likewise `sel_b_i` for B. With divide value N (1 to 255), the divider output goes high together with every N-th pulse of the selected tap and is low otherwise, so N=1 passes the tap through.
- R5: A divide value of 0 holds that divider's output low, whatever its select value.
- R6: Select values 11 to 15 hold that divider's output low.
- R7: Dividers A and B run independently; the settings of one have no effect on the output of the other.
- R8: While `enable_i` is low, `tap_o[10:1]` and both divider outputs are low, and the prescaler and divider counts are held at zero. After the first enabled cycle (cycle 0), tap k first pulses in cycle 2^k-1.
- R9: When a divider's select or divide input differs from its value in the previous cycle, that divider's output is low in that cycle and its count restarts. Its next pulse coincides with the N-th selected-tap pulse after that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Master enable; low stops all taps except the undivided one |
| sel_a_i | input | 4 | Tap select for divider A (0..10 valid) |
| div_a_i | input | 8 | Divide value for divider A (0 = off) |
| sel_b_i | input | 4 | Tap select for divider B (0..10 valid) |
| div_b_i | input | 8 | Divide value for divider B (0 = off) |
| tap_o | output | 11 | Prescaler strobes, bit k at ratio 2^k |
| clk_a_o | output | 1 | Divider A strobe |
| clk_b_o | output | 1 | Divider B strobe |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a divider's count, because the divider then has to drop its partial count and start again from the next tap pulse. The stimulus walks a table of configurations in which every entry changes both dividers at once. Each change arrives at an arbitrary prescaler phase, so it interrupts a count that is already running. The bench then counts the selected tap's pulses at the ports and expects a divider pulse exactly on every N-th one. A directed case shortens the divide value after four cycles of a longer count. Another holds a configuration across a disable period, which shows that the count was cleared while the block was disabled.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
    localparam int PK_NUM_TAPS = 11;
    localparam int PK_SEL_W    = 4;
    localparam int PK_DIV_W    = 8;
    localparam int PK_NUM_DIV  = 2;
endpackage

// File: rtl/pwm_tap_prescaler.sv
module pwm_tap_prescaler #(
    parameter int NUM_TAPS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    output logic [NUM_TAPS-1:0] tap_o
);
    localparam int CNT_W = NUM_TAPS - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_o[0] = 1'b1;

    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
        assign tap_o[k] = enable_i & (&st_q.cnt[k-1:0]);
    end
endmodule

// File: rtl/pwm_lin_divider.sv
module pwm_lin_divider #(
    parameter int NUM_TAPS = 11,
    parameter int SEL_W    = 4,
    parameter int DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [DIV_W-1:0]    div_i,
    output logic                strobe_o
);
    localparam logic [SEL_W-1:0]    SEL_LIMIT = SEL_W'(NUM_TAPS);
    localparam logic [NUM_TAPS-1:0] TAP_ONE   = NUM_TAPS'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       cfg_moved;
    logic       running;
    logic       tap_hit;
    logic       at_last;
    logic       pulse;

    always_comb begin
        cfg_moved = (sel_i != st_q.sel) || (div_i != st_q.div);
        running   = enable_i && (div_i != '0) && (sel_i < SEL_LIMIT);
        tap_hit   = |(taps_i & (TAP_ONE << sel_i));
        at_last   = (st_q.cnt == (div_i - DIV_W'(1)));
        pulse     = running && !cfg_moved && tap_hit && at_last;

        st_d      = st_q;
        st_d.sel  = sel_i;
        st_d.div  = div_i;
        if (!running || cfg_moved) begin
            st_d.cnt = '0;
        end else if (tap_hit) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = pulse;
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
    import pwm_clkgen_pkg::*;
#(
    parameter int NUM_TAPS = PK_NUM_TAPS,
    parameter int SEL_W    = PK_SEL_W,
    parameter int DIV_W    = PK_DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [SEL_W-1:0]    sel_a_i,
    input  logic [DIV_W-1:0]    div_a_i,
    input  logic [SEL_W-1:0]    sel_b_i,
    input  logic [DIV_W-1:0]    div_b_i,
    output logic [NUM_TAPS-1:0] tap_o,
    output logic                clk_a_o,
    output logic                clk_b_o
);
    localparam int NUM_DIV = PK_NUM_DIV;

    logic [SEL_W-1:0]   sel_arr [NUM_DIV];
    logic [DIV_W-1:0]   div_arr [NUM_DIV];
    logic [NUM_DIV-1:0] dstrobe;
    logic [NUM_TAPS-1:0] taps;

    assign sel_arr[0] = sel_a_i;
    assign sel_arr[1] = sel_b_i;
    assign div_arr[0] = div_a_i;
    assign div_arr[1] = div_b_i;

    pwm_tap_prescaler #(.NUM_TAPS(NUM_TAPS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .tap_o    (taps)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        pwm_lin_divider #(
            .NUM_TAPS (NUM_TAPS),
            .SEL_W    (SEL_W),
            .DIV_W    (DIV_W)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (enable_i),
            .taps_i   (taps),
            .sel_i    (sel_arr[g]),
            .div_i    (div_arr[g]),
            .strobe_o (dstrobe[g])
        );
    end

    assign tap_o   = taps;
    assign clk_a_o = dstrobe[0];
    assign clk_b_o = dstrobe[1];
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk
    import pwm_clkgen_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable_i,
    input logic [PK_SEL_W-1:0]    sel_a_i,
    input logic [PK_DIV_W-1:0]    div_a_i,
    input logic [PK_SEL_W-1:0]    sel_b_i,
    input logic [PK_DIV_W-1:0]    div_b_i,
    input logic [PK_NUM_TAPS-1:0] tap_o,
    input logic                   clk_a_o,
    input logic                   clk_b_o
);
    localparam logic [PK_NUM_TAPS-1:0] ONE = PK_NUM_TAPS'(1);
    localparam logic [PK_SEL_W-1:0]    LIM = PK_SEL_W'(PK_NUM_TAPS);

    // R1: a slower tap only fires together with every faster one
    for (genvar k = 1; k < PK_NUM_TAPS; k++) begin : g_nest
        a_r1_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
            tap_o[k] |-> tap_o[k-1]);
    end

    // R1: the half-rate tap never fires in two cycles in a row
    a_r1_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[1] |=> !tap_o[1]);

    // R2
    a_r2_undivided_on: assert property (@(posedge clk) tap_o[0]);

    // R3
    a_r3_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (tap_o[PK_NUM_TAPS-1:1] == '0) && !clk_a_o && !clk_b_o);

    // R4: a divider pulse always coincides with its selected tap
    a_r4_a_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
        clk_a_o |-> |(tap_o & (ONE << sel_a_i)));
    a_r4_b_on_tap: assert property (@(posedge clk) disable iff (!rst_n)
        clk_b_o |-> |(tap_o & (ONE << sel_b_i)));

    // R5
    a_r5_zero_div_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_a_i == '0) |-> !clk_a_o) and ((div_b_i == '0) |-> !clk_b_o));

    // R6
    a_r6_bad_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_a_i >= LIM) |-> !clk_a_o) and ((sel_b_i >= LIM) |-> !clk_b_o));

    // R8
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (tap_o[PK_NUM_TAPS-1:1] == '0) && !clk_a_o && !clk_b_o);
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_i) |-> (tap_o[PK_NUM_TAPS-1:1] == '0));

    // R9
    a_r9_a_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel_a_i) || !$stable(div_a_i)) |-> !clk_a_o);
    a_r9_b_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel_b_i) || !$stable(div_b_i)) |-> !clk_b_o);
endmodule

bind pwm_clkgen pwm_clkgen_chk u_chk (.*);

// File: tb/pwm_clkgen_bench.sv
module pwm_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [3:0]  sel_a_i = '0;
    logic [7:0]  div_a_i = '0;
    logic [3:0]  sel_b_i = '0;
    logic [7:0]  div_b_i = '0;
    logic [10:0] tap_o;
    logic        clk_a_o;
    logic        clk_b_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pwm_clkgen u_pwm_clkgen (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    // columns: sel_a, div_a, sel_b, div_b (every row changes both dividers)
    localparam int NVEC = 7;
    localparam int VEC [NVEC][4] = '{
        '{0, 1,   0, 2},
        '{1, 3,   0, 5},
        '{3, 2,   2, 7},
        '{0, 255, 4, 3},
        '{2, 1,   1, 1},
        '{10, 2,  5, 4},
        '{6, 9,   3, 30}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Follow both dividers from a config change: each must pulse on exactly every
    // N-th pulse of its selected tap (R4, R7, R9).
    task automatic run_vec(input int sa, input int na, input int sb, input int nb);
        int tpa = 0, tpb = 0, pa = 0, pb = 0, bada = 0, badb = 0;
        bit ea, eb;
        @(negedge clk);
        sel_a_i = 4'(sa); div_a_i = 8'(na);
        sel_b_i = 4'(sb); div_b_i = 8'(nb);
        for (int c = 0; c < 20000 && (pa < 2 || pb < 2); c++) begin
            @(negedge clk);
            ea = 1'b0; eb = 1'b0;
            if (tap_o[sa]) begin tpa++; ea = (tpa % na) == 0; end
            if (tap_o[sb]) begin tpb++; eb = (tpb % nb) == 0; end
            if (clk_a_o != ea) bada++;
            if (clk_b_o != eb) badb++;
            if (ea) pa++;
            if (eb) pb++;
        end
        chk(bada == 0 && pa >= 2, "R4/R9 divider A", bada, 0);
        chk(badb == 0 && pb >= 2, "R7/R9 divider B", badb, 0);
    endtask

    initial begin
        int bad;
        int tb [11];
        // R3 reset state
        sel_a_i = 4'd0; div_a_i = 8'd1;
        repeat (3) @(negedge clk);
        chk(tap_o == 11'b1, "R3 taps in reset", int'(tap_o), 1);
        chk(!clk_a_o && !clk_b_o, "R3 dividers in reset", int'({clk_a_o, clk_b_o}), 0);
        chk(tap_o[0] == 1'b1, "R2 undivided tap in reset", int'(tap_o[0]), 1);
        rst_n = 1'b1;
        div_a_i = 8'd0;
        repeat (3) @(negedge clk);
        chk(tap_o == 11'b1, "R8 taps while disabled", int'(tap_o), 1);

        // R1 and R8: tap k fires in cycle j exactly when j mod 2^k == 2^k-1
        enable_i = 1'b1;
        for (int k = 0; k < 11; k++) tb[k] = 0;
        for (int j = 1; j <= 2048; j++) begin
            @(negedge clk);
            for (int k = 0; k < 11; k++)
                if (tap_o[k] != ((j % (1 << k)) == ((1 << k) - 1))) tb[k]++;
        end
        for (int k = 0; k < 11; k++)
            chk(tb[k] == 0, "R1/R8 tap timing", tb[k], 0);

        // Table of divider configurations
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

        // R5: zero divide value keeps output low
        @(negedge clk);
        sel_a_i = 4'd0; div_a_i = 8'd0; sel_b_i = 4'd5; div_b_i = 8'd0;
        bad = 0;
        repeat (200) begin @(negedge clk); if (clk_a_o || clk_b_o) bad++; end
        chk(bad == 0, "R5 zero divide off", bad, 0);

        // R6: out-of-range selects keep output low
        sel_a_i = 4'd11; div_a_i = 8'd1; sel_b_i = 4'd15; div_b_i = 8'd1;
        bad = 0;
        repeat (200) begin @(negedge clk); if (clk_a_o || clk_b_o) bad++; end
        chk(bad == 0, "R6 bad select off", bad, 0);

        // R9: shorten the divide value mid-count
        sel_a_i = 4'd0; div_a_i = 8'd6; sel_b_i = 4'd0; div_b_i = 8'd0;
        repeat (4) @(negedge clk);
        div_a_i = 8'd3;
        bad = 0;
        repeat (2) begin @(negedge clk); if (clk_a_o) bad++; end
        @(negedge clk);
        chk(bad == 0 && clk_a_o, "R9 restart after change", int'(clk_a_o), 1);

        // R8: disable mid-run, then restart with an unchanged config
        sel_a_i = 4'd1; div_a_i = 8'd2; sel_b_i = 4'd0; div_b_i = 8'd1;
        repeat (5) @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        chk(tap_o == 11'b1 && !clk_a_o && !clk_b_o, "R8 disable clears outputs",
            int'({tap_o, clk_a_o, clk_b_o}), 4);
        chk(tap_o[0] == 1'b1, "R2 undivided tap while disabled", int'(tap_o[0]), 1);
        repeat (3) @(negedge clk);
        enable_i = 1'b1;
        bad = 0;
        @(negedge clk); if (clk_a_o) bad++;   // cycle 1: first half-rate tap pulse
        @(negedge clk); if (clk_a_o) bad++;
        @(negedge clk);                       // cycle 3: second half-rate tap pulse
        chk(bad == 0 && clk_a_o, "R8 divider count cleared by disable", int'(clk_a_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule